// File: doc/BRIEF.md
# Keyed-restart watchdog timer

A down-counting watchdog behind a 32-bit word register interface. Software sets a reload value, enables the counter through a control word, and keeps it alive by writing a 16-bit key to a restart register. If the count reaches zero first, the block emits single-cycle expiry pulses (reset request, interrupt, external signal), each enabled by its own control bit. It then stays at zero until software restarts or re-enables it.

Each decrement happens either on every clock cycle or on cycles where a 1 MHz strobe input is high. A control bit picks the source, and the choice is latched whenever the counter is loaded. The timeout status, timeout clear and reset-width slots are present in the map but are inert. Every access is a single-cycle request. Read data is combinational from the address.

Top module: `wdog_timer`

## Requirements
- R1: After reset the count (0x00) and reload (0x04) registers read 0x03EF1480, control (0x0C) reads 0, and all pulse outputs and `addr_err_o` are low.
- R2: The reload register at 0x04 is read/write. The count register at 0x00 returns the live count, and writes to it are ignored.
- R3: A write to 0x08 loads the count from the reload register only when data bits [15:0] equal 0x4755. Bits [31:16] are don't-care, any other value is ignored, and reading 0x08 returns 0.
- R4: Control bits are: [0] enable, [1] reset request on expiry, [2] interrupt on expiry, [3] external pulse on expiry, [4] 1 MHz tick select, [5] full-chip reset mode. A control write is stored only if its bit 0 differs from the stored bit 0. Bits [31:6] read as 0.
- R5: A write that sets enable loads the count from reload on that edge, and counting starts on the next edge. A write that clears enable freezes the count at its current value.
- R6: With the tick select latched low, the count drops by one every clock. With it latched high, the count drops only on cycles where `tick_1m_i` is high. The select is latched from the written data on enable, and from the stored control bit on a keyed restart.
- R7: The decrement edge that takes the count from 1 to 0 is followed by one-cycle pulses: `rst_req_o` if bit 1 is set, `irq_o` if bit 2 is set, and `ext_o` if bit 3 is set. `rst_full_o` follows control bit 5.
- R8: After expiry the count stays 0 and no further pulses occur until a keyed restart or a new enable loads it again.
- R9: Offsets 0x10, 0x14 and 0x18 read as 0, and writes to them change nothing.
- R10: An access with a misaligned address or an offset above 0x18 reads 0, changes nothing, and sets the sticky `addr_err_o`. Only reset clears `addr_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| tick_1m_i | input | 1 | 1 MHz tick strobe |
| rst_req_o | output | 1 | Reset request pulse on expiry |
| rst_full_o | output | 1 | Reset scope: 1 full chip, 0 SoC only |
| irq_o | output | 1 | Interrupt pulse on expiry |
| ext_o | output | 1 | External signal pulse on expiry |
| addr_err_o | output | 1 | Sticky bad-address flag |

## Verification
A wrong count shows up on the very next read of offset 0x00. A bad decrement rate moves the expiry pulse away from the exact cycle predicted from the reload value. A stuck expired flag shows as either a missing second pulse after restart or a repeated pulse without one. Misrouted decode shows at once as wrong read data or a spurious error flag. The bench times expiry to the exact cycle in both tick modes, so an off-by-one in the load or decrement path fails within a few cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW = 32;
  localparam int CTRL_W = 6;

  localparam int OFF_COUNT   = 'h00;
  localparam int OFF_RELOAD  = 'h04;
  localparam int OFF_RESTART = 'h08;
  localparam int OFF_CTRL    = 'h0C;
  localparam int OFF_TSTAT   = 'h10;
  localparam int OFF_TCLR    = 'h14;
  localparam int OFF_RWIDTH  = 'h18;

  localparam logic [15:0] RESTART_KEY = 16'h4755;

  localparam int CB_EN   = 0;
  localparam int CB_RST  = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_EXT  = 3;
  localparam int CB_SEL  = 4;
  localparam int CB_MODE = 5;

  localparam int N_ACT = 3;

  typedef enum logic [2:0] {
    SEL_COUNT, SEL_RELOAD, SEL_RESTART, SEL_CTRL,
    SEL_TSTAT, SEL_TCLR, SEL_RWIDTH, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_LOAD = CNT_W'(32'h03EF1480)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              load_o,
  output logic              load_sel_o,
  output logic              err_o
);
  localparam int IDX_W = ADDR_W - 2;

  reg_sel_e          sel;
  logic [IDX_W-1:0]  idx;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic              err_q;
  logic              wr, restart_ok, ctrl_wr, en_rise;

  assign idx = addr_i[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      case (idx)
        IDX_W'(OFF_COUNT   >> 2): sel = SEL_COUNT;
        IDX_W'(OFF_RELOAD  >> 2): sel = SEL_RELOAD;
        IDX_W'(OFF_RESTART >> 2): sel = SEL_RESTART;
        IDX_W'(OFF_CTRL    >> 2): sel = SEL_CTRL;
        IDX_W'(OFF_TSTAT   >> 2): sel = SEL_TSTAT;
        IDX_W'(OFF_TCLR    >> 2): sel = SEL_TCLR;
        IDX_W'(OFF_RWIDTH  >> 2): sel = SEL_RWIDTH;
        default:                  sel = SEL_NONE;
      endcase
    end
  end

  assign wr         = req_i & we_i;
  assign restart_ok = wr & (sel == SEL_RESTART) & (wdata_i[15:0] == RESTART_KEY);
  // control only accepted when it flips the enable bit
  assign ctrl_wr    = wr & (sel == SEL_CTRL) & (wdata_i[CB_EN] != ctrl_q[CB_EN]);
  assign en_rise    = ctrl_wr & wdata_i[CB_EN];
  assign load_o     = restart_ok | en_rise;
  assign load_sel_o = en_rise ? wdata_i[CB_SEL] : ctrl_q[CB_SEL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= RST_LOAD;
      err_q    <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr && sel == SEL_RELOAD) reload_q <= wdata_i[CNT_W-1:0];
      if (req_i && sel == SEL_NONE) err_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_COUNT:  rdata_o = DW'(count_i);
      SEL_RELOAD: rdata_o = DW'(reload_q);
      SEL_CTRL:   rdata_o = DW'(ctrl_q);
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign err_o    = err_q;

  // R4
  ctrl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_CTRL) && wdata_i[CB_EN] == ctrl_q[CB_EN])
    |=> $stable(ctrl_q));
  // R3
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_RESTART) && wdata_i[15:0] != RESTART_KEY)
    |-> !load_o);
  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_LOAD = CNT_W'(32'h03EF1480)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             load_sel_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             tick_1m_i,
  input  logic [N_ACT-1:0] act_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic [N_ACT-1:0] pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             expired_q, sel_q;
  logic             tick, run, hit;
  logic [N_ACT-1:0] pulse_q;

  assign tick = sel_q ? tick_1m_i : 1'b1;
  assign run  = en_i & ~expired_q;
  // final decrement (a zero load also expires on the next tick)
  assign hit  = run & tick & (cnt_q <= CNT_W'(1)) & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= RST_LOAD;
      expired_q <= 1'b0;
      sel_q     <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= reload_i;
      expired_q <= 1'b0;
      sel_q     <= load_sel_i;
    end else if (hit) begin
      cnt_q     <= '0;
      expired_q <= 1'b1;
    end else if (run && tick) begin
      cnt_q     <= cnt_q - CNT_W'(1);
    end
  end

  for (genvar g = 0; g < N_ACT; g++) begin : g_act
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q[g] <= 1'b0;
      else         pulse_q[g] <= hit & act_en_i[g];
    end
  end

  assign count_o = cnt_q;
  assign pulse_o = pulse_q;

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q));
  // R8
  expired_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_q && !load_i) |=> (cnt_q == '0 && pulse_q == '0));
  // R7
  pulse_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulse_q) |-> (cnt_q == '0 && expired_q));
  // R6
  no_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_LOAD = CNT_W'(32'h03EF1480)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_1m_i,
  output logic              rst_req_o,
  output logic              rst_full_o,
  output logic              irq_o,
  output logic              ext_o,
  output logic              addr_err_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  reload, count;
  logic              load, load_sel;
  logic [N_ACT-1:0]  pulse;

  wdog_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RST_LOAD(RST_LOAD)) u_regif (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .count_i(count), .ctrl_o(ctrl), .reload_o(reload),
    .load_o(load), .load_sel_o(load_sel), .err_o(addr_err_o)
  );

  wdog_core #(.CNT_W(CNT_W), .RST_LOAD(RST_LOAD)) u_core (
    .clk_i, .rst_ni,
    .en_i(ctrl[CB_EN]), .load_i(load), .load_sel_i(load_sel),
    .reload_i(reload), .tick_1m_i,
    .act_en_i(ctrl[CB_EXT:CB_RST]),
    .count_o(count), .pulse_o(pulse)
  );

  assign rst_req_o  = pulse[0];
  assign irq_o      = pulse[1];
  assign ext_o      = pulse[2];
  assign rst_full_o = ctrl[CB_MODE];
endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rst_req, rst_full, irq, ext, aerr;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_1m_i(tick),
    .rst_req_o(rst_req), .rst_full_o(rst_full), .irq_o(irq), .ext_o(ext),
    .addr_err_o(aerr)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h00, 32'h0,         32'h03EF1480, 4'd1},  // R1
    '{1'b0, 8'h04, 32'h0,         32'h03EF1480, 4'd1},  // R1
    '{1'b0, 8'h0C, 32'h0,         32'h0,        4'd1},  // R1
    '{1'b1, 8'h04, 32'h00001234,  32'h0,        4'd2},  // R2
    '{1'b0, 8'h04, 32'h0,         32'h00001234, 4'd2},  // R2
    '{1'b1, 8'h00, 32'hFFFFFFFF,  32'h0,        4'd2},  // R2
    '{1'b0, 8'h00, 32'h0,         32'h03EF1480, 4'd2},  // R2
    '{1'b1, 8'h08, 32'h00001111,  32'h0,        4'd3},  // R3
    '{1'b0, 8'h00, 32'h0,         32'h03EF1480, 4'd3},  // R3
    '{1'b1, 8'h08, 32'hABCD4755,  32'h0,        4'd3},  // R3
    '{1'b0, 8'h00, 32'h0,         32'h00001234, 4'd3},  // R3
    '{1'b0, 8'h08, 32'h0,         32'h0,        4'd3},  // R3
    '{1'b1, 8'h10, 32'hFFFFFFFF,  32'h0,        4'd9},  // R9
    '{1'b0, 8'h10, 32'h0,         32'h0,        4'd9},  // R9
    '{1'b0, 8'h14, 32'h0,         32'h0,        4'd9},  // R9
    '{1'b1, 8'h0C, 32'h0000003E,  32'h0,        4'd4},  // R4
    '{1'b0, 8'h0C, 32'h0,         32'h0,        4'd4}   // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all access tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 rst_req", 32'(rst_req), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ext", 32'(ext), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr_err", 32'(aerr), 0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].we) wr(TBL[i].addr, TBL[i].data);
      else begin
        rd(TBL[i].addr, d);
        chk($sformatf("R%0d vec%0d", TBL[i].req, i), d, TBL[i].exp);
      end
    end
    chk("R9 no addr_err", 32'(aerr), 0);

    // R5 R7: clock-rate counting to expiry, reset+irq, full mode
    wr(8'h04, 32'd5);
    wr(8'h0C, 32'h27);
    peek(8'h00, d); chk("R5 load", d, 5);
    chk("R7 full mode", 32'(rst_full), 1);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      peek(8'h00, d);
      chk("R6 count", d, 32'(5 - i));
      chk("R7 rst_req", 32'(rst_req), 32'(i == 5));
      chk("R7 irq", 32'(irq), 32'(i == 5));
      chk("R7 ext", 32'(ext), 0);
    end
    // R8: stays at zero, no more pulses
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      peek(8'h00, d);
      chk("R8 count", d, 0);
      chk("R8 rst_req", 32'(rst_req), 0);
      chk("R8 irq", 32'(irq), 0);
    end
    // R8 R3: keyed restart revives it
    wr(8'h08, 32'h00004755);
    peek(8'h00, d); chk("R8 restart", d, 5);
    @(negedge clk);
    peek(8'h00, d); chk("R8 running", d, 4);
    // R5: disable freezes (one decrement on the write edge)
    wr(8'h0C, 32'h26);
    peek(8'h00, d); chk("R5 stop", d, 3);
    repeat (3) @(negedge clk);
    peek(8'h00, d); chk("R5 hold", d, 3);
    peek(8'h0C, d); chk("R4 ctrl", d, 32'h26);

    // R6: 1 MHz mode with ext pulse only
    wr(8'h0C, 32'h19);
    peek(8'h00, d); chk("R6 load", d, 5);
    repeat (2) @(negedge clk);
    peek(8'h00, d); chk("R6 no tick", d, 5);
    for (int i = 1; i <= 5; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      peek(8'h00, d);
      chk("R6 tick count", d, 32'(5 - i));
      chk("R7 ext", 32'(ext), 32'(i == 5));
      chk("R7 rst_req off", 32'(rst_req), 0);
      chk("R7 irq off", 32'(irq), 0);
    end
    @(negedge clk);
    chk("R8 ext once", 32'(ext), 0);
    chk("R7 soc mode", 32'(rst_full), 0);
    // R4: same-enable write dropped
    wr(8'h0C, 32'h1B);
    peek(8'h0C, d); chk("R4 dropped", d, 32'h19);

    // R10: bad addresses
    chk("R10 pre", 32'(aerr), 0);
    rd(8'h1C, d); chk("R10 high rd", d, 0);
    chk("R10 flag", 32'(aerr), 1);
    rd(8'h05, d); chk("R10 misaligned rd", d, 0);
    wr(8'h40, 32'd99);
    wr(8'h06, 32'd77);
    peek(8'h04, d); chk("R10 no write", d, 5);
    repeat (2) @(negedge clk);
    chk("R10 sticky", 32'(aerr), 1);

    finish_run();
  end
endmodule